// File: doc/BRIEF.md
# External Program Memory Download Steering

This block decides who owns an external program memory bus. In normal operation the DSP program counter drives the external address, and a fetch is marked as external when the counter lies in the upper half of the program space. When the internal/external split pin is low, every address is marked external. When the host sets load mode with direct access cleared, the bus is taken over by two host-writable 16-bit registers: one holds the memory address and one holds the memory data. Each register is written one byte at a time through a byte-wide host register port.

A host write to the high byte of the data register is the trigger that writes memory. The external write strobe is a gated copy of the host write strobe, so it lasts exactly as long as the host pulse. No wait-state setting lengthens it. The high data byte is forwarded from the host data lines while the strobe is active. The word presented to memory therefore already carries the new byte for the whole pulse. A download is a sequence of host writes: address low, address high, data low, then data high. The last of these writes the memory.

Top module: `pml_loader`

## Requirements
- R1: After reset, the address register and the data register both read as zero once load mode is entered, and `ext_we` is 0.
- R2: When the bus is not taken over by the host and `split_en` is 1, `fetch_ext` is 1 exactly when `dsp_pc` is 0x8000 or above, and `ext_addr` equals `dsp_pc`.
- R3: When the bus is not taken over by the host and `split_en` is 0, `fetch_ext` is 1 for every `dsp_pc` value, and `ext_addr` equals `dsp_pc`.
- R4: When `load_mode` is 1 and `direct_acc` is 0, `ext_addr` is {byte at 0x45, byte at 0x44}, `ext_wdata` is {byte at 0x47, byte at 0x46}, and `fetch_ext` is 0.
- R5: In load mode, a host write to 0x47 drives `ext_we` high in the same cycle that `host_wr` rises, and low in the same cycle that `host_wr` falls. No clock edge is involved.
- R6: Host writes to 0x44, 0x45 and 0x46 never raise `ext_we`.
- R7: When `load_mode` is 0 or `direct_acc` is 1, `ext_we` stays 0 for every host write, `ext_wdata` is 0, and the host registers do not affect `ext_addr`.
- R8: While a write to 0x47 is active, bits 15:8 of `ext_wdata` equal `host_wdata`, including before the first clock edge of the pulse.
- R9: Host writes to addresses outside 0x44..0x47 leave all four register bytes unchanged.
- R10: The host registers capture writes in every mode. A byte written outside load mode appears on the bus once load mode is entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data byte |
| host_wr | input | 1 | Host write strobe, active high |
| load_mode | input | 1 | Download mode request |
| direct_acc | input | 1 | Direct access; blocks the host takeover when 1 |
| split_en | input | 1 | 1: only the upper half of program space is external; 0: all of it is external |
| dsp_pc | input | 16 | DSP program fetch address |
| ext_addr | output | 16 | External memory address |
| ext_wdata | output | 16 | External memory write data |
| ext_we | output | 1 | External memory write strobe, active high |
| fetch_ext | output | 1 | Current DSP fetch goes to external memory |

## Verification
The assertions assume three things about the inputs:
- A host write keeps `host_addr` and `host_wdata` steady for as long as `host_wr` is high.
- `host_wr` is never high during reset.
- The mode inputs do not change while a host write is active.

The stimulus meets these assumptions by changing every input only on the falling clock edge. Each host write is a held pulse whose address and data are fixed before the strobe rises. The mode bits are changed only between writes.

// File: rtl/pml_pkg.sv
package pml_pkg;

  // Who currently owns the external memory bus.
  typedef enum logic {
    SRC_DSP  = 1'b0,
    SRC_HOST = 1'b1
  } bus_src_e;

  // The host owns the bus only with load mode set and direct access clear.
  function automatic bus_src_e pick_source(input logic load, input logic direct);
    return (load && !direct) ? SRC_HOST : SRC_DSP;
  endfunction

  // A fetch is external when the split is off, or when the top address bit is set.
  function automatic logic fetch_is_ext(input logic split, input logic pc_msb);
    return !split || pc_msb;
  endfunction

endpackage

// File: rtl/pml_byte_regs.sv
module pml_byte_regs #(
  parameter int unsigned AW          = 8,
  parameter int unsigned NB          = 2,
  parameter logic [AW-1:0] BASE      = 8'h44,
  parameter bit          BYPASS_TOP  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [NB*8-1:0] word,
  output logic [NB-1:0]   hit
);

  logic [7:0] q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [AW-1:0] SLOT = AW'(BASE + AW'(i));

    assign hit[i] = wr && (addr == SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 8'h00;
      else if (hit[i]) q[i] <= wdata;
    end

    if (BYPASS_TOP && (i == NB - 1)) begin : g_fwd
      // The top byte is forwarded from the host lines while its write is active.
      assign word[i*8 +: 8] = hit[i] ? wdata : q[i];
      p_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |-> (word[i*8 +: 8] == wdata));
    end else begin : g_plain
      assign word[i*8 +: 8] = q[i];
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(q[i]));
    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> (q[i] == $past(wdata)));
  end

endmodule

// File: rtl/pml_fetch_route.sv
module pml_fetch_route
  import pml_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_src_e src,
  input  logic     split_en,
  input  logic     pc_msb,
  output logic     fetch_ext
);

  assign fetch_ext = (src == SRC_DSP) && fetch_is_ext(split_en, pc_msb);

  p_upper_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DSP && split_en && pc_msb) |-> fetch_ext);
  p_lower_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en && !pc_msb) |-> !fetch_ext);
  p_all_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DSP && !split_en) |-> fetch_ext);
  p_host_nofetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_HOST) |-> !fetch_ext);

endmodule

// File: rtl/pml_strobe_gen.sv
module pml_strobe_gen
  import pml_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_src_e src,
  input  logic     host_wr,
  input  logic     top_hit,
  output logic     ext_we
);

  // Purely combinational: the strobe follows host_wr edge for edge.
  assign ext_we = (src == SRC_HOST) && top_hit;

  p_we_needs_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> host_wr);
  p_we_only_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DSP) |-> !ext_we);

endmodule

// File: rtl/pml_loader.sv
module pml_loader
  import pml_pkg::*;
#(
  parameter int unsigned   PC_W     = 16,
  parameter int unsigned   DATA_W   = 16,
  parameter int unsigned   HOST_AW  = 8,
  parameter logic [7:0]    ADR_BASE = 8'h44,
  parameter logic [7:0]    DAT_BASE = 8'h46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              load_mode,
  input  logic              direct_acc,
  input  logic              split_en,
  input  logic [PC_W-1:0]   dsp_pc,
  output logic [PC_W-1:0]   ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_we,
  output logic              fetch_ext
);

  localparam int unsigned ANB = PC_W / 8;
  localparam int unsigned DNB = DATA_W / 8;

  bus_src_e          src;
  logic [PC_W-1:0]   adr_word;
  logic [DATA_W-1:0] dat_word;
  logic [ANB-1:0]    adr_hit;
  logic [DNB-1:0]    dat_hit;

  assign src = pick_source(load_mode, direct_acc);

  pml_byte_regs #(.AW(HOST_AW), .NB(ANB), .BASE(HOST_AW'(ADR_BASE)), .BYPASS_TOP(1'b0)) u_adr (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .word(adr_word), .hit(adr_hit)
  );

  pml_byte_regs #(.AW(HOST_AW), .NB(DNB), .BASE(HOST_AW'(DAT_BASE)), .BYPASS_TOP(1'b1)) u_dat (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .word(dat_word), .hit(dat_hit)
  );

  pml_fetch_route u_route (
    .clk(clk), .rst_n(rst_n), .src(src), .split_en(split_en),
    .pc_msb(dsp_pc[PC_W-1]), .fetch_ext(fetch_ext)
  );

  pml_strobe_gen u_stb (
    .clk(clk), .rst_n(rst_n), .src(src), .host_wr(host_wr),
    .top_hit(dat_hit[DNB-1]), .ext_we(ext_we)
  );

  assign ext_addr  = (src == SRC_HOST) ? adr_word : dsp_pc;
  assign ext_wdata = (src == SRC_HOST) ? dat_word : '0;

  p_low_bytes_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|adr_hit || |dat_hit[DNB-2:0]) |-> !ext_we);
  p_pc_on_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_mode && !direct_acc) |-> (ext_addr == dsp_pc && ext_wdata == '0));
  p_host_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mode && !direct_acc && !host_wr) |-> !ext_we);

endmodule

// File: tb/tb_pml_loader.sv
module tb_pml_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        load_mode = 1'b0;
  logic        direct_acc = 1'b0;
  logic        split_en = 1'b1;
  logic [15:0] dsp_pc = '0;
  logic [15:0] ext_addr;
  logic [15:0] ext_wdata;
  logic        ext_we;
  logic        fetch_ext;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pml_loader dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .load_mode(load_mode), .direct_acc(direct_acc),
    .split_en(split_en), .dsp_pc(dsp_pc), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_we(ext_we), .fetch_ext(fetch_ext)
  );

  // Routing vectors, one per row: {load, direct, split, pc[15:0], expected fetch_ext}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 16'h8000, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'h0000, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'h7FFF, 1'b1},
    {1'b1, 1'b1, 1'b1, 16'h1234, 1'b0},
    {1'b1, 1'b1, 1'b0, 16'h9ABC, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Host write held for 'len' cycles. ext_we is sampled right after the rise,
  // once in each held cycle, and right after the fall.
  task automatic hwrite(input logic [7:0] a, input logic [7:0] d, input int len,
                        input logic exp_we, input string req);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #1 chk({req, " strobe at rise"}, 32'(ext_we), 32'(exp_we));
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      #1 chk({req, " strobe held"}, 32'(ext_we), 32'(exp_we));
    end
    @(negedge clk);
    host_wr = 1'b0;
    #1 chk({req, " strobe after fall"}, 32'(ext_we), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, viewed through the load-mode bus
    @(negedge clk);
    load_mode = 1'b1; direct_acc = 1'b0;
    #2;
    chk("R1 addr", 32'(ext_addr), 32'h0);
    chk("R1 data", 32'(ext_wdata), 32'h0);
    chk("R1 we", 32'(ext_we), 32'h0);

    // Routing table (R2, R3, R7)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {load_mode, direct_acc, split_en, dsp_pc} = VEC[i][20:1];
      #2;
      chk(split_en ? "R2 fetch" : "R3 fetch", 32'(fetch_ext), 32'(VEC[i][0]));
      chk(split_en ? "R2 addr" : "R3 addr", 32'(ext_addr), 32'(VEC[i][16:1]));
      chk("R7 wdata zero", 32'(ext_wdata), 32'h0);
    end

    // Download sequence in load mode
    @(negedge clk);
    load_mode = 1'b1; direct_acc = 1'b0; split_en = 1'b1; dsp_pc = 16'hC000;
    hwrite(8'h44, 8'h34, 2, 1'b0, "R6 0x44");
    hwrite(8'h45, 8'h12, 1, 1'b0, "R6 0x45");
    hwrite(8'h46, 8'hCD, 3, 1'b0, "R6 0x46");
    #2;
    chk("R4 addr", 32'(ext_addr), 32'h1234);
    chk("R4 data", 32'(ext_wdata), 32'h00CD);
    chk("R4 fetch", 32'(fetch_ext), 32'h0);

    // R8: new high byte is on the bus before the first clock edge of the pulse
    @(negedge clk);
    host_addr = 8'h47; host_wdata = 8'hAB; host_wr = 1'b1;
    #1 chk("R8 forwarded byte", 32'(ext_wdata), 32'hABCD);
    chk("R5 rise", 32'(ext_we), 32'h1);
    @(negedge clk);
    #1 chk("R5 held", 32'(ext_we), 32'h1);
    @(negedge clk);
    host_wr = 1'b0;
    #1 chk("R5 fall", 32'(ext_we), 32'h0);
    chk("R8 captured byte", 32'(ext_wdata), 32'hABCD);

    // A one-cycle pulse has the same strobe behaviour.
    hwrite(8'h47, 8'h11, 1, 1'b1, "R5 short");

    // R9: writes to neighbouring addresses are ignored.
    hwrite(8'h48, 8'hFF, 2, 1'b0, "R9 0x48");
    hwrite(8'h43, 8'hEE, 1, 1'b0, "R9 0x43");
    #2;
    chk("R9 addr", 32'(ext_addr), 32'h1234);
    chk("R9 data", 32'(ext_wdata), 32'h11CD);

    // R7: outside load mode there is no strobe and the PC is on the bus.
    @(negedge clk);
    load_mode = 1'b0; dsp_pc = 16'h4321;
    hwrite(8'h47, 8'h5A, 2, 1'b0, "R7 no load");
    #2;
    chk("R7 addr", 32'(ext_addr), 32'h4321);
    @(negedge clk);
    load_mode = 1'b1; direct_acc = 1'b1;
    hwrite(8'h47, 8'h5A, 1, 1'b0, "R7 direct");

    // R10: the byte written outside load mode appears once load mode is entered.
    @(negedge clk);
    direct_acc = 1'b0;
    #2;
    chk("R10 data", 32'(ext_wdata), 32'h5ACD);

    // R1: a second reset clears the registers.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 re-reset addr", 32'(ext_addr), 32'h0);
    chk("R1 re-reset data", 32'(ext_wdata), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule